// File: doc/BRIEF.md
# I2C Register Initialization Sequencer

This block loads the control registers of a video transmitter at power-up over a two-wire I2C bus. After reset it waits out a power-up delay, then works through a fixed, ordered table of register/value pairs. Each pair goes out as a complete single-register write transaction of its own, and after the last pair the block raises `done`. It acts only as a bus master, drives both lines open-drain (an enable that pulls the line low), and reads back SDA only to sample the acknowledge bit.

The serial clock comes from a divider that produces four evenly spaced phase ticks per SCL period. SDA is changed in the middle of the low half and sampled in the middle of the high half. If an acknowledge is missing, the current transaction is closed with a STOP, the rest of the table is dropped and `error` is set. A `start` pulse given after the block has finished, whether it succeeded or failed, reloads the whole table from the first pair.

Top module: `vtx_cfg_loader`

## Requirements
- R1: While reset is active and during the power-up wait of `PWRUP_CYCLES` clocks after it, `busy`, `done`, `error`, `scl_oe` and `sda_oe` are all low. The first START condition appears no earlier than `PWRUP_CYCLES` clocks and no later than `PWRUP_CYCLES + 4*CLK_DIV_QTR + 10` clocks after reset is released.
- R2: Every transaction has this sequence: START, then the write address byte 0xEC (7-bit address 0x76 with R/W = 0), then the register byte, then the value byte, then STOP. Each byte is followed by an acknowledge clock.
- R3: The table is sent one pair per transaction, in exactly this order (register, value): (9C,00) (9D,4C) (9F,80) (A1,00) (B3,08) (B4,16) (B6,60) (C9,C0) (C8,19). The test-pattern register C8 therefore follows the power-management register C9.
- R4: Bytes are sent MSB first. Apart from START and STOP, SDA changes only while SCL is low. A START happens only outside a transaction, and a STOP happens only right after an acknowledge clock.
- R5: During the ninth (acknowledge) clock of each byte the master releases SDA. A low level sampled there counts as an acknowledge.
- R6: If SDA is sampled high in any acknowledge clock, the block ends that transaction with a STOP and starts no further transaction. It then sets `error` with `busy` and `done` low, and `error` stays high until a retrigger.
- R7: From one STOP to the next START, both lines stay released for at least `4*CLK_DIV_QTR` clocks.
- R8: The SCL period inside a transaction is exactly `4*CLK_DIV_QTR` system clocks. The default of 320 gives about 195 kHz from a 250 MHz clock.
- R9: `busy` goes high before the first START and stays high through the final STOP. Whenever `busy` is low, both line enables are low. `done` rises in the cycle `busy` falls after a fully acknowledged table and stays high.
- R10: `start` has no effect while `busy` is high or during the power-up wait. A `start` while `done` or `error` is high restarts from the first pair, and in the next cycle `done` and `error` are low and `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Retrigger pulse, acted on only after the block has finished or failed |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | Pulls SCL low when high |
| sda_oe | output | 1 | Pulls SDA low when high |
| busy | output | 1 | A table load is in progress |
| done | output | 1 | The whole table was written and acknowledged |
| error | output | 1 | The load stopped on a missing acknowledge |

## Verification
A `start` request can arrive in the same stretch of cycles in which a load is still running or has just finished, and the block must tell these two cases apart. The bench pulses `start` in the middle of a load and expects exactly nine transactions with no restart. It then pulses `start` right after `done` or `error` has been set and expects the flags to clear in the next cycle and a fresh, complete table to follow. A bus monitor counts START and STOP events, the decoded bytes and the acknowledge ownership to judge both cases. A refused acknowledge is injected on the address byte and on the register byte, and the bench checks that the transaction in progress still closes cleanly.

// File: rtl/vtx_cfg_pkg.sv
package vtx_cfg_pkg;

   localparam int unsigned TABLE_LEN = 9;

   typedef struct packed {
      logic [7:0] reg_addr;
      logic [7:0] value;
   } cfg_pair_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_BITS,
      PH_STOP,
      PH_GAP
   } bus_phase_t;

   typedef enum logic [2:0] {
      SQ_POWERUP,
      SQ_ISSUE,
      SQ_WAIT,
      SQ_DONE,
      SQ_FAIL
   } seq_state_t;

   // Ordered initialization table; the test-pattern write must stay last.
   function automatic cfg_pair_t cfg_entry(input int unsigned idx);
      cfg_pair_t p;
      case (idx)
         0:       p = '{reg_addr: 8'h9C, value: 8'h00};
         1:       p = '{reg_addr: 8'h9D, value: 8'h4C};
         2:       p = '{reg_addr: 8'h9F, value: 8'h80};
         3:       p = '{reg_addr: 8'hA1, value: 8'h00};
         4:       p = '{reg_addr: 8'hB3, value: 8'h08};
         5:       p = '{reg_addr: 8'hB4, value: 8'h16};
         6:       p = '{reg_addr: 8'hB6, value: 8'h60};
         7:       p = '{reg_addr: 8'hC9, value: 8'hC0};
         8:       p = '{reg_addr: 8'hC8, value: 8'h19};
         default: p = '{reg_addr: 8'h00, value: 8'h00};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/vtx_cfg_sync.sv
module vtx_cfg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   generate
      if (STAGES <= 1) begin : g_one
         logic r;
         always_ff @(posedge clk) begin
            if (rst) r <= 1'b1;
            else     r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk) begin
            if (rst) r <= '1;
            else     r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/vtx_cfg_qtick.sv
module vtx_cfg_qtick #(
   parameter int unsigned QTR_CYCLES = 320
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic tick
);

   localparam int unsigned CW = (QTR_CYCLES > 2) ? $clog2(QTR_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

   logic [CW-1:0] cnt;

   // Counter is held cleared while disabled so each transaction starts on a fresh phase.
   always_ff @(posedge clk) begin
      if (rst || !en)        cnt <= '0;
      else if (cnt == LAST)  cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   assign tick = en && (cnt == LAST);

endmodule

// File: rtl/vtx_cfg_xfer.sv
module vtx_cfg_xfer
   import vtx_cfg_pkg::*;
#(
   parameter int unsigned QTR_CYCLES  = 320,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_ADDR7   = 7'h76
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       go,
   input  logic [7:0] reg_addr,
   input  logic [7:0] value,
   input  logic       sda_in,
   output logic       scl_low,
   output logic       sda_low,
   output logic       fin,
   output logic       nacked
);

   localparam logic [7:0] DEV_WBYTE = {DEV_ADDR7, 1'b0};
   localparam logic [1:0] LAST_BYTE = 2'd2;
   localparam logic [3:0] ACK_SLOT  = 4'd8;

   bus_phase_t ph;
   logic [1:0] q;
   logic [3:0] bit_cnt;
   logic [1:0] byte_sel;
   logic [7:0] addr_q, val_q, cur_byte;
   logic       ack_hi, tick, sda_s;

   vtx_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
   );

   vtx_cfg_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
      .clk(clk), .rst(rst), .en(ph != PH_IDLE), .tick(tick)
   );

   always_comb begin
      case (byte_sel)
         2'd0:    cur_byte = DEV_WBYTE;
         2'd1:    cur_byte = addr_q;
         default: cur_byte = val_q;
      endcase
   end

   // Quarter phases per bit slot: q0 set SDA, q1 SCL up, q2 sample, q3 SCL down.
   always_ff @(posedge clk) begin
      if (rst) begin
         ph       <= PH_IDLE;
         q        <= 2'd0;
         bit_cnt  <= 4'd0;
         byte_sel <= 2'd0;
         addr_q   <= 8'h00;
         val_q    <= 8'h00;
         ack_hi   <= 1'b0;
         scl_low  <= 1'b0;
         sda_low  <= 1'b0;
         fin      <= 1'b0;
         nacked   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (ph == PH_IDLE) begin
            if (go) begin
               ph     <= PH_START;
               q      <= 2'd0;
               addr_q <= reg_addr;
               val_q  <= value;
               nacked <= 1'b0;
            end
         end else if (tick) begin
            q <= q + 2'd1;
            case (ph)
               PH_START: begin
                  if (q == 2'd2) sda_low <= 1'b1;
                  if (q == 2'd3) begin
                     scl_low  <= 1'b1;
                     ph       <= PH_BITS;
                     bit_cnt  <= 4'd0;
                     byte_sel <= 2'd0;
                  end
               end
               PH_BITS: begin
                  case (q)
                     2'd0: sda_low <= (bit_cnt == ACK_SLOT) ? 1'b0
                                      : ~cur_byte[3'd7 - bit_cnt[2:0]];
                     2'd1: scl_low <= 1'b0;
                     2'd2: ack_hi  <= sda_s;
                     default: begin
                        scl_low <= 1'b1;
                        if (bit_cnt == ACK_SLOT) begin
                           bit_cnt <= 4'd0;
                           if (ack_hi) begin
                              nacked <= 1'b1;
                              ph     <= PH_STOP;
                           end else if (byte_sel == LAST_BYTE) begin
                              ph <= PH_STOP;
                           end else begin
                              byte_sel <= byte_sel + 2'd1;
                           end
                        end else begin
                           bit_cnt <= bit_cnt + 4'd1;
                        end
                     end
                  endcase
               end
               PH_STOP: begin
                  case (q)
                     2'd0:    sda_low <= 1'b1;
                     2'd1:    scl_low <= 1'b0;
                     2'd2:    sda_low <= 1'b0;
                     default: ph      <= PH_GAP;
                  endcase
               end
               PH_GAP: begin
                  if (q == 2'd3) begin
                     ph  <= PH_IDLE;
                     fin <= 1'b1;
                  end
               end
               default: ph <= PH_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/vtx_cfg_loader.sv
module vtx_cfg_loader
   import vtx_cfg_pkg::*;
#(
   parameter int unsigned CLK_DIV_QTR  = 320,
   parameter int unsigned PWRUP_CYCLES = 25000,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter logic [6:0]  DEV_ADDR7    = 7'h76,
   parameter int unsigned ENTRIES      = TABLE_LEN
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic sda_in,
   output logic scl_oe,
   output logic sda_oe,
   output logic busy,
   output logic done,
   output logic error
);

   localparam int unsigned PW = $clog2(PWRUP_CYCLES + 1);
   localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [PW-1:0] PW_LAST  = PW'(PWRUP_CYCLES - 1);
   localparam logic [IW-1:0] IDX_LAST = IW'(ENTRIES - 1);

   generate
      if (CLK_DIV_QTR < 2) begin : g_bad_div
         $error("CLK_DIV_QTR must be 2 or more");
      end
      if (PWRUP_CYCLES < 1) begin : g_bad_pwr
         $error("PWRUP_CYCLES must be 1 or more");
      end
      if (ENTRIES < 1 || ENTRIES > TABLE_LEN) begin : g_bad_len
         $error("ENTRIES must lie within the table length");
      end
   endgenerate

   seq_state_t    st;
   logic [PW-1:0] pw_cnt;
   logic [IW-1:0] idx;
   logic          go, fin, nacked;
   cfg_pair_t     ent;

   assign ent = cfg_entry(32'(idx));

   vtx_cfg_xfer #(
      .QTR_CYCLES (CLK_DIV_QTR),
      .SYNC_STAGES(SYNC_STAGES),
      .DEV_ADDR7  (DEV_ADDR7)
   ) u_xfer (
      .clk     (clk),
      .rst     (rst),
      .go      (go),
      .reg_addr(ent.reg_addr),
      .value   (ent.value),
      .sda_in  (sda_in),
      .scl_low (scl_oe),
      .sda_low (sda_oe),
      .fin     (fin),
      .nacked  (nacked)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= SQ_POWERUP;
         pw_cnt <= '0;
         idx    <= '0;
         go     <= 1'b0;
         busy   <= 1'b0;
         done   <= 1'b0;
         error  <= 1'b0;
      end else begin
         go <= 1'b0;
         case (st)
            SQ_POWERUP: begin
               if (pw_cnt == PW_LAST) begin
                  st   <= SQ_ISSUE;
                  idx  <= '0;
                  busy <= 1'b1;
               end else begin
                  pw_cnt <= pw_cnt + 1'b1;
               end
            end
            SQ_ISSUE: begin
               go <= 1'b1;
               st <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (fin) begin
                  if (nacked) begin
                     st    <= SQ_FAIL;
                     busy  <= 1'b0;
                     error <= 1'b1;
                  end else if (idx == IDX_LAST) begin
                     st   <= SQ_DONE;
                     busy <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= SQ_ISSUE;
                  end
               end
            end
            default: begin
               if (start) begin
                  st    <= SQ_ISSUE;
                  idx   <= '0;
                  busy  <= 1'b1;
                  done  <= 1'b0;
                  error <= 1'b0;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/vtx_cfg_loader_chk.sv
module vtx_cfg_loader_chk (
   input logic clk,
   input logic rst,
   input logic start,
   input logic scl_oe,
   input logic sda_oe,
   input logic busy,
   input logic done,
   input logic error
);

   a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
      !(done && busy));

   a_r6_error_not_done: assert property (@(posedge clk) disable iff (rst)
      !(done && error));

   a_r9_idle_lines: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (!scl_oe && !sda_oe));

   a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> $past(busy));

   a_r9_done_held: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> done);

   a_r6_error_held: assert property (@(posedge clk) disable iff (rst)
      (error && !start) |=> error);

   a_r10_retrigger: assert property (@(posedge clk) disable iff (rst)
      ((done || error) && start) |=> (busy && !done && !error));

endmodule

bind vtx_cfg_loader vtx_cfg_loader_chk u_chk (
   .clk   (clk),
   .rst   (rst),
   .start (start),
   .scl_oe(scl_oe),
   .sda_oe(sda_oe),
   .busy  (busy),
   .done  (done),
   .error (error)
);

// File: tb/vtx_cfg_loader_bench.sv
module vtx_cfg_loader_bench;

   localparam int QTR = 4;
   localparam int PWR = 60;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic scl_oe, sda_oe, busy, done, error;
   logic slv_low = 1'b0;
   logic scl_w, sda_w;

   always #2 clk = ~clk;

   assign scl_w = !scl_oe;
   assign sda_w = !(sda_oe || slv_low);

   vtx_cfg_loader #(
      .CLK_DIV_QTR (QTR),
      .PWRUP_CYCLES(PWR)
   ) u_vtx_cfg_loader (
      .clk(clk), .rst(rst), .start(start), .sda_in(sda_w),
      .scl_oe(scl_oe), .sda_oe(sda_oe),
      .busy(busy), .done(done), .error(error)
   );

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_pair(input int k);
      case (k)
         0: return 32'h9C00;
         1: return 32'h9D4C;
         2: return 32'h9F80;
         3: return 32'hA100;
         4: return 32'hB308;
         5: return 32'hB416;
         6: return 32'hB660;
         7: return 32'hC9C0;
         8: return 32'hC819;
         default: return 0;
      endcase
   endfunction

   // ---------------- bus monitor and responder ----------------
   int cyc = 0;
   int first_start = -1;
   int last_stop = 0;
   bit have_stop = 1'b0;
   bit in_frame = 1'b0;
   int bitcnt = 0;
   int last_rise = -1;
   logic [7:0] shreg = 8'h00;
   logic [7:0] cb [0:2];
   logic [7:0] t_dev [0:63];
   logic [7:0] t_reg [0:63];
   logic [7:0] t_dat [0:63];
   int t_nb [0:63];
   int txn_cnt = 0;
   int err_frame = 0, err_ack = 0, err_gap = 0, err_period = 0, err_busy = 0;
   int nack_txn = -1;
   int nack_byte = 0;
   bit p_scl = 1'b1, p_sda = 1'b1;

   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         if (p_scl && scl_w && p_sda && !sda_w) begin
            if (in_frame) err_frame++;
            if (!busy) err_busy++;
            if (have_stop && (cyc - last_stop) < 4*QTR) err_gap++;
            if (first_start < 0) first_start = cyc;
            in_frame = 1'b1; bitcnt = 0; last_rise = -1;
            cb[0] = 8'h00; cb[1] = 8'h00; cb[2] = 8'h00;
         end else if (p_scl && scl_w && !p_sda && sda_w) begin
            if (!in_frame || bitcnt < 10 || (bitcnt % 9) != 1) err_frame++;
            if (!busy) err_busy++;
            if (in_frame && txn_cnt < 64) begin
               t_dev[txn_cnt] = cb[0]; t_reg[txn_cnt] = cb[1]; t_dat[txn_cnt] = cb[2];
               t_nb[txn_cnt] = (bitcnt - 1) / 9;
               txn_cnt++;
            end
            in_frame = 1'b0; last_stop = cyc; have_stop = 1'b1;
         end
         if (in_frame && !p_scl && scl_w) begin
            if (last_rise >= 0 && (cyc - last_rise) != 4*QTR) err_period++;
            last_rise = cyc;
            if ((bitcnt % 9) == 8) begin
               if (sda_oe) err_ack++;
            end else begin
               shreg = {shreg[6:0], sda_w};
               if ((bitcnt % 9) == 7 && (bitcnt / 9) < 3) cb[bitcnt / 9] = shreg;
            end
            bitcnt++;
         end
         if (in_frame && p_scl && !scl_w) begin
            if ((bitcnt % 9) == 8)
               slv_low = !(txn_cnt == nack_txn && (bitcnt / 9) == nack_byte);
            else
               slv_low = 1'b0;
         end
      end
      p_scl = scl_w;
      p_sda = sda_w;
   end

   // ---------------- helpers ----------------
   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_end(output bit timed_out);
      timed_out = 1'b1;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (done || error) begin timed_out = 1'b0; break; end
      end
   endtask

   task automatic check_table(input int base, input string req);
      for (int k = 0; k < 9; k++) begin
         chk(t_dev[base+k] == 8'hEC, "R2", "address byte", int'(t_dev[base+k]), 32'hEC);
         chk({t_reg[base+k], t_dat[base+k]} == 16'(exp_pair(k)), req, "reg/value pair",
             int'({t_reg[base+k], t_dat[base+k]}), exp_pair(k));
         chk(t_nb[base+k] == 3, "R2", "bytes per transaction", t_nb[base+k], 3);
      end
   endtask

   task automatic check_bus_clean();
      chk(err_frame == 0, "R4", "misplaced START/STOP", err_frame, 0);
      chk(err_ack == 0, "R5", "master drove SDA in ack clock", err_ack, 0);
      chk(err_gap == 0, "R7", "short idle gap", err_gap, 0);
      chk(err_period == 0, "R8", "SCL period mismatch", err_period, 0);
      chk(err_busy == 0, "R9", "bus event while not busy", err_busy, 0);
   endtask

   // ---------------- scenarios ----------------
   int rel_cyc = 0;

   task automatic t_powerup();
      repeat (4) @(negedge clk);
      chk(!busy && !done && !error, "R1", "flags in reset", int'({busy, done, error}), 0);
      chk(!scl_oe && !sda_oe, "R1", "lines in reset", int'({scl_oe, sda_oe}), 0);
      rst = 1'b0; rel_cyc = cyc;
      repeat (5) @(negedge clk);
      pulse_start();   // R10: ignored during the power-up wait
      repeat (PWR/2 - 10) @(negedge clk);
      chk(!busy && !scl_oe && !sda_oe, "R1", "idle during power-up wait",
          int'({busy, scl_oe, sda_oe}), 0);
      for (int i = 0; i < PWR + 8*QTR + 40; i++) begin
         @(negedge clk);
         if (first_start >= 0) break;
      end
      chk(first_start >= rel_cyc + PWR && first_start <= rel_cyc + PWR + 4*QTR + 10,
          "R1", "first START delay", first_start - rel_cyc, PWR);
   endtask

   task automatic t_full();
      bit to;
      wait_end(to);
      chk(!to, "R9", "load finished", int'(to), 0);
      chk(done && !error && !busy, "R9", "flags after load", int'({busy, done, error}), 3'b010);
      chk(txn_cnt == 9, "R3", "transaction count", txn_cnt, 9);
      check_table(0, "R3");
      check_bus_clean();
   endtask

   task automatic t_hold();
      int base = txn_cnt;
      repeat (300) @(negedge clk);
      chk(done && !busy, "R9", "done held", int'({busy, done}), 1);
      chk(!scl_oe && !sda_oe, "R9", "lines released when idle", int'({scl_oe, sda_oe}), 0);
      chk(txn_cnt == base, "R10", "no traffic without start", txn_cnt - base, 0);
   endtask

   task automatic t_retrigger_busy();
      bit to;
      int base = txn_cnt;
      pulse_start();
      chk(busy && !done && !error, "R10", "retrigger clears flags", int'({busy, done, error}), 3'b100);
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (txn_cnt >= base + 3) break;
      end
      pulse_start();   // must not restart the running load
      chk(busy && !done, "R10", "still busy after start mid-load", int'({busy, done}), 2);
      wait_end(to);
      chk(!to && done, "R10", "load completed", int'({to, done}), 1);
      chk(txn_cnt - base == 9, "R10", "no restart mid-load", txn_cnt - base, 9);
      check_table(base, "R10");
      check_bus_clean();
   endtask

   task automatic t_nack(input int entry, input int byte_no);
      bit to;
      int base = txn_cnt;
      nack_txn = base + entry;
      nack_byte = byte_no;
      pulse_start();
      wait_end(to);
      chk(!to && error, "R6", "error raised", int'({to, error}), 1);
      chk(!done && !busy, "R6", "done and busy low on error", int'({busy, done}), 0);
      chk(txn_cnt - base == entry + 1, "R6", "transactions before abort", txn_cnt - base, entry + 1);
      chk(t_nb[base+entry] == byte_no + 1, "R6", "bytes in aborted transaction",
          t_nb[base+entry], byte_no + 1);
      chk(t_dev[base+entry] == 8'hEC, "R2", "address byte of aborted transaction",
          int'(t_dev[base+entry]), 32'hEC);
      repeat (1000) @(negedge clk);
      chk(txn_cnt - base == entry + 1, "R6", "no traffic after abort", txn_cnt - base, entry + 1);
      chk(error && !scl_oe && !sda_oe, "R6", "error held, lines idle",
          int'({error, scl_oe, sda_oe}), 4);
      check_bus_clean();
      nack_txn = -1;
   endtask

   task automatic t_recover();
      bit to;
      int base = txn_cnt;
      pulse_start();
      chk(!error && busy && !done, "R10", "error cleared by retrigger", int'({busy, done, error}), 4);
      wait_end(to);
      chk(!to && done && !error, "R10", "clean load after error", int'({to, done, error}), 2);
      chk(txn_cnt - base == 9, "R3", "full table after recovery", txn_cnt - base, 9);
      check_table(base, "R3");
   endtask

   initial begin
      t_powerup();
      t_full();
      t_hold();
      t_retrigger_busy();
      t_nack(4, 1);
      t_recover();
      t_nack(0, 0);
      t_recover();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule